// File: doc/BRIEF.md
# Serial Byte Receiver with Break and Runt Filtering

This block receives asynchronous serial characters in the fixed format of eight data bits, no parity and one stop bit. It runs entirely in one 125 MHz system clock domain and hands each received character to downstream logic through an AXI-Stream master port. A one-bit user side-band marks characters whose stop bit was sampled low. One input picks the line rate: 4,000,000 baud or 115,200 baud.

The serial line is first passed through a two-flop synchronizer. It is then sampled at sixteen times the bit rate, with ticks from a fractional phase accumulator. This keeps the 31.25-cycle bit period of the fast rate accurate without a clock change. A start bit must still be low at its midpoint, or the receiver drops it as a runt and goes back to idle. After a low stop bit, the receiver waits for the line to return high before it looks for a new start bit. A held break therefore yields a single error character.

Top module: `uart_byte_rx`

## Requirements
- R1: After reset, m_valid and m_user are low.
- R2: With rate_fast=1, a frame of a low start bit, eight data bits sent least significant bit first and a high stop bit is delivered as one transfer whose m_data equals the eight bits (bit 0 received first) and whose m_user is 0.
- R3: A low pulse on rxd that has returned high by the middle of the start bit produces no transfer.
- R4: When the stop bit is sampled low, the character is still delivered, with the data bits as received and m_user set to 1.
- R5: A line held low for many bit times produces exactly one transfer with m_user=1 and m_data=0x00. A normal frame sent after the line returns high is received correctly.
- R6: rate_fast=1 selects 4,000,000 baud and rate_fast=0 selects 115,200 baud. Bit timing derives from a 16x tick whose phase accumulator stays below the clock rate. rate_fast must stay constant during a frame.
- R7: While m_valid is high and m_ready is low, m_valid stays high and m_data and m_user stay unchanged.
- R8: A character that completes while an earlier one is still waiting for m_ready is discarded. Only the earlier one is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_fast | input | 1 | 1 selects 4,000,000 baud, 0 selects 115,200 baud |
| rxd | input | 1 | Asynchronous serial input, idle high |
| m_valid | output | 1 | Stream valid |
| m_ready | input | 1 | Stream ready from the consumer |
| m_data | output | 8 | Received character |
| m_user | output | 1 | 1 when the stop bit was sampled low (frame error or break) |

## Verification
A drifting tick phase or a miscounted tick index moves the sample point toward a bit edge. At 4 Mbaud this corrupts the upper data bits of the very first frame, and it shows up on m_data one cycle after the middle of the stop bit. A receiver stuck in its wait-for-high state, or one that leaves it too early, shows within one frame: either no transfer after a break ends, or a stream of error characters while the break is held. Runt filtering and the single-entry output stage are checked by counting transfers, since any spurious or lost character changes that count directly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned OVS = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD
  } rx_state_t;

  // Phase increment per clock for a 16x sample tick at the chosen rate.
  function automatic int unsigned tick_step(input logic fast,
                                            input int unsigned slow_baud,
                                            input int unsigned fast_baud);
    return (fast ? fast_baud : slow_baud) * OVS;
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned SLOW_BAUD = 115_200,
  parameter int unsigned FAST_BAUD = 4_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic fast,
  output logic tick
);
  import uart_rx_pkg::*;

  localparam int unsigned ACC_W = $clog2(CLK_HZ) + 1;
  localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] sum;

  always_comb begin
    step = ACC_W'(tick_step(fast, SLOW_BAUD, FAST_BAUD));
    sum  = acc + step;
  end

  assign tick = !clear && (sum >= WRAP);

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (tick)    acc <= sum - WRAP;
    else              acc <= sum;
  end

  // R6: fractional phase never reaches a full clock-rate unit
  assert_acc_bound_R6: assert property (@(posedge clk) disable iff (rst)
    acc < WRAP);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx,
  input  logic                 tick,
  output logic                 timer_clear,
  output logic                 done,
  output logic                 frame_err,
  output logic [DATA_BITS-1:0] char_out
);
  import uart_rx_pkg::*;

  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned IDX_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rx_state_t              state;
  logic [CNT_W-1:0]       tcnt;
  logic [IDX_W-1:0]       bidx;
  logic [DATA_BITS-1:0]   shreg;
  logic                   mid_tick;
  logic                   end_tick;

  assign mid_tick    = tick && (tcnt == MID_CNT);
  assign end_tick    = tick && (tcnt == LAST_CNT);
  assign timer_clear = (state == ST_IDLE);
  assign char_out    = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      done      <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          tcnt <= '0;
          bidx <= '0;
          if (!rx) state <= ST_START;
        end
        ST_START: begin
          if (mid_tick) begin
            tcnt <= '0;
            state <= rx ? ST_IDLE : ST_DATA;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (end_tick) begin
            shreg <= {rx, shreg[DATA_BITS-1:1]};
            bidx  <= bidx + 1'b1;
            if (bidx == LAST_IDX) state <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (end_tick) begin
            done      <= 1'b1;
            frame_err <= !rx;
            state     <= rx ? ST_IDLE : ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (rx) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a start bit found high at its middle is dropped with no character
  assert_runt_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && mid_tick && rx) |=> (state == ST_IDLE && !done));

  // R4: characters are only reported after the stop-bit sample
  assert_done_from_stop_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(state) == ST_STOP));

  // R5: an error character always leaves the receiver waiting for a high line
  assert_err_waits_R5: assert property (@(posedge clk) disable iff (rst)
    (done && frame_err) |-> (state == ST_HOLD));

  // R5: while the line stays low after an error, nothing more is reported
  assert_single_break_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !rx) |=> (!done && state == ST_HOLD));
endmodule

// File: rtl/uart_byte_rx.sv
module uart_byte_rx #(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned SLOW_BAUD = 115_200,
  parameter int unsigned FAST_BAUD = 4_000_000,
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rate_fast,
  input  logic                 rxd,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [DATA_BITS-1:0] m_data,
  output logic                 m_user
);
  logic                 rx_s;
  logic                 tick;
  logic                 timer_clear;
  logic                 done;
  logic                 frame_err;
  logic [DATA_BITS-1:0] char_out;
  logic                 can_load;

  rx_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (rxd),
    .d_sync  (rx_s)
  );

  rx_tick_gen #(
    .CLK_HZ    (CLK_HZ),
    .SLOW_BAUD (SLOW_BAUD),
    .FAST_BAUD (FAST_BAUD)
  ) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (timer_clear),
    .fast  (rate_fast),
    .tick  (tick)
  );

  rx_frame_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .rx          (rx_s),
    .tick        (tick),
    .timer_clear (timer_clear),
    .done        (done),
    .frame_err   (frame_err),
    .char_out    (char_out)
  );

  assign can_load = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_user  <= 1'b0;
    end else if (done && can_load) begin
      m_valid <= 1'b1;
      m_data  <= char_out;
      m_user  <= frame_err;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R7: stalled output keeps its payload
  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_user)));

  // R8: a character finishing during a stall leaves the pending one in place
  assert_drop_new_R8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready && done) |=> $stable(m_data));
endmodule

// File: tb/tb_uart_byte_rx.sv
module tb_uart_byte_rx;
  localparam int CLK_PERIOD = 8;
  localparam longint CLK_HZ = 125_000_000;
  localparam longint FAST   = 4_000_000;
  localparam longint SLOW   = 115_200;
  localparam int WATCHDOG   = 190_000;

  // {rate_fast, character, stop level}
  localparam int NVEC = 8;
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b1, 8'h55, 1'b1}, {1'b1, 8'hA3, 1'b1}, {1'b1, 8'h00, 1'b1},
    {1'b1, 8'hFF, 1'b1}, {1'b1, 8'h01, 1'b1}, {1'b1, 8'h80, 1'b1},
    {1'b1, 8'h3C, 1'b0}, {1'b0, 8'hC5, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rate_fast = 1'b1;
  logic       rxd = 1'b1;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [7:0] m_data;
  logic       m_user;

  int checks = 0;
  int errors = 0;
  int got_count = 0;
  logic [7:0] got_data = '0;
  logic       got_user = 1'b0;
  bit         finished = 1'b0;

  uart_byte_rx dut (
    .clk       (clk),
    .rst       (rst),
    .rate_fast (rate_fast),
    .rxd       (rxd),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_user    (m_user)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst && m_valid && m_ready) begin
      got_count <= got_count + 1;
      got_data  <= m_data;
      got_user  <= m_user;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_frame(input logic fast, input logic [7:0] ch, input logic stop);
    logic [9:0] bits;
    longint baud;
    longint ncyc;
    bits = {stop, ch, 1'b0};
    baud = fast ? FAST : SLOW;
    ncyc = (10 * CLK_HZ) / baud;
    rate_fast = fast;
    for (longint c = 0; c < ncyc; c++) begin
      @(negedge clk);
      rxd = bits[int'((c * baud) / CLK_HZ)];
    end
    @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    idle(5);
    rst = 1'b0;
    idle(2);
    chk(m_valid == 1'b0, "R1", "m_valid after reset", m_valid, 0);
    chk(m_user == 1'b0, "R1", "m_user after reset", m_user, 0);
    idle(20);

    // table of frames: R2 fast good stop, R4 bad stop, R6 slow rate
    for (int v = 0; v < NVEC; v++) begin
      string req;
      req = VEC[v][9] ? (VEC[v][0] ? "R2" : "R4") : "R6";
      base = got_count;
      send_frame(VEC[v][9], VEC[v][8:1], VEC[v][0]);
      idle(40);
      chk(got_count == base + 1, req, "transfer count", got_count, base + 1);
      chk(got_data == VEC[v][8:1], req, "data", got_data, VEC[v][8:1]);
      chk(got_user == !VEC[v][0], req, "user flag", got_user, !VEC[v][0]);
    end

    // R3: short low glitch at fast rate
    rate_fast = 1'b1;
    idle(10);
    base = got_count;
    rxd = 1'b0;
    idle(8);
    rxd = 1'b1;
    idle(400);
    chk(got_count == base, "R3", "runt produced transfer", got_count, base);
    send_frame(1'b1, 8'h96, 1'b1);
    idle(40);
    chk(got_count == base + 1 && got_data == 8'h96, "R3", "frame after runt",
        got_data, 8'h96);

    // R5: held break gives one error character
    base = got_count;
    rxd = 1'b0;
    idle(3000);
    rxd = 1'b1;
    idle(100);
    chk(got_count == base + 1, "R5", "break transfer count", got_count, base + 1);
    chk(got_user == 1'b1, "R5", "break user flag", got_user, 1);
    chk(got_data == 8'h00, "R5", "break data", got_data, 0);
    send_frame(1'b1, 8'h6B, 1'b1);
    idle(40);
    chk(got_count == base + 2, "R5", "count after break", got_count, base + 2);
    chk(got_data == 8'h6B && got_user == 1'b0, "R5", "frame after break",
        got_data, 8'h6B);

    // R7 / R8: stall with two frames
    base = got_count;
    m_ready = 1'b0;
    send_frame(1'b1, 8'h5A, 1'b1);
    idle(40);
    chk(m_valid == 1'b1 && m_data == 8'h5A, "R7", "pending first char", m_data, 8'h5A);
    send_frame(1'b1, 8'hE1, 0);
    idle(40);
    chk(m_valid == 1'b1 && m_data == 8'h5A && m_user == 1'b0, "R8",
        "pending kept over second", m_data, 8'h5A);
    chk(got_count == base, "R7", "no transfer while stalled", got_count, base);
    m_ready = 1'b1;
    idle(3);
    chk(got_count == base + 1 && got_data == 8'h5A, "R8", "first char delivered",
        got_data, 8'h5A);
    idle(400);
    chk(got_count == base + 1, "R8", "second char discarded", got_count, base + 1);
    chk(m_valid == 1'b0, "R7", "valid cleared after accept", m_valid, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule